// File: doc/BRIEF.md
# Sleep State Sequencer

This block turns two active-low sleep request lines (deep sleep and soft-off), a sleep-support enable for the 5 V dual rail and three main-supply monitor results into a power state: active, suspend (S3) or soft-off (S5). It also has a power-up/shutdown state called OFF. The block runs on one clock and uses a one-microsecond tick strobe for all of its timing. A glitch filter cleans both request lines. When the suspend line falls, a fixed delay runs. After the delay the soft-off line is sampled, and that value picks which sleep state is entered. Moves straight from one sleep state to the other are refused.

The outputs control the pass elements of the 5 V dual rail and the clock rail. In the active state the main-supply gate is driven. In a sleep state the standby gate is driven only if the sleep-support setting latched at sleep entry was 1. The two gates are never on together, and at least one cycle with both off separates them. If a main supply drops while the block is active, it is forced into soft-off. A shutdown request sends the block to OFF from any state.

Top module: `acpi_sleep_ctrl`

## Requirements
- R1: While reset is asserted, pwr_state is OFF (encoding 3) and main_gate_en, stby_gate_en and clk_rail_en are all 0. The state encoding is ACTIVE=0, S3=1, S5=2, OFF=3.
- R2: In OFF with shutdown_req low, the next state is S5. The sleep-support input is sampled on every cycle spent in OFF.
- R3: A request line is synchronised by two flops. A new level is accepted only after it has stayed different from the accepted level on FILT_TICKS consecutive ticks. A shorter pulse leaves the state unchanged.
- R4: In ACTIVE, the sleep delay counts ticks while the filtered suspend line is low. After DELAY_US ticks the block enters S3 if the filtered soft-off line is high, or S5 if it is low. If the suspend line returns high before the count ends, the delay is cancelled and restarts from zero.
- R5: The block never moves directly from S3 to S5 or from S5 to S3. A request for the other sleep state keeps the present state.
- R6: The combination "suspend line high, soft-off line low" keeps the present state, both in ACTIVE and in a sleep state.
- R7: From S3 or S5, the block returns to ACTIVE on the next cycle when both filtered lines are high and all three supply monitors report good.
- R8: In ACTIVE, any supply monitor reporting low moves the block to S5 on the next cycle. It stays in S5 until all monitors report good again.
- R9: The sleep-support input is latched when ACTIVE hands over to S3 or S5. Changes on the input while in sleep do not affect stby_gate_en.
- R10: In ACTIVE, main_gate_en is on. In S3 or S5, stby_gate_en equals the latched sleep-support value. Each gate follows the state with one register of delay.
- R11: clk_rail_en is 1 only while pwr_state is ACTIVE.
- R12: main_gate_en and stby_gate_en are never both 1. A gate only turns on in a cycle after the other gate was off.
- R13: shutdown_req moves the block to OFF on the next cycle from any state. Both gates are off one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| slp3_req_n | input | 1 | Suspend request, active low, asynchronous |
| slp5_req_n | input | 1 | Soft-off request, active low, asynchronous |
| dual_sleep_en | input | 1 | Keep the 5 V dual rail on during sleep |
| mon_3v3_ok | input | 1 | 3.3 V main supply above threshold |
| mon_5v_ok | input | 1 | 5 V main supply above threshold |
| mon_12v_ok | input | 1 | 12 V main supply above threshold |
| shutdown_req | input | 1 | Forces all outputs off and holds OFF |
| pwr_state | output | 2 | Current state (ACTIVE=0, S3=1, S5=2, OFF=3) |
| main_gate_en | output | 1 | Gate drive for pass elements fed from the main supplies |
| stby_gate_en | output | 1 | Gate drive for the standby 5 V dual switch |
| clk_rail_en | output | 1 | Enable for the clock-chip rail |

## Verification
The bench drives short pulses on the suspend line. A filter that counted cycles instead of ticks, or that did not reset its count, would let these pulses start a sleep entry. It also drops the suspend line and raises it again partway through the delay, which catches a timer that keeps its count and then enters sleep too early. From each sleep state it requests the other sleep state and the illegal line combination; a design that followed the lines would step between sleep states. It also toggles the sleep-support input while asleep, where a design that kept re-sampling it would turn the standby gate on, and it removes a supply while active to check the forced soft-off and its release.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_S3     = 2'd1,
    PS_S5     = 2'd2,
    PS_OFF    = 2'd3
  } pwr_state_t;

  localparam int unsigned REQ_N = 2;   // index 0: suspend line, 1: soft-off line

endpackage

// File: rtl/sst_deglitch.sv
module sst_deglitch #(
  parameter int unsigned FILT_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_n,
  output logic filt_n
);
  localparam int unsigned CNT_W = (FILT_TICKS < 2) ? 1 : $clog2(FILT_TICKS);

  logic             sync1_q, sync2_q;
  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // two-flop synchroniser for the off-chip line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= raw_n;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (sync2_q == filt_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == CNT_W'(FILT_TICKS - 1)) begin
        filt_d = sync2_q;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_n = filt_q;

endmodule

// File: rtl/sst_sleep_timer.sv
module sst_sleep_timer #(
  parameter int unsigned DELAY_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic done
);
  localparam int unsigned TMR_W = $clog2(DELAY_US + 1);
  localparam logic [TMR_W-1:0] LIMIT = TMR_W'(DELAY_US);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = !run || (tick && (cnt_q != LIMIT));

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LIMIT);

endmodule

// File: rtl/sst_gate_drive.sv
module sst_gate_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic want_main,
  input  logic want_stby,
  output logic main_en,
  output logic stby_en
);
  logic main_q, stby_q, main_d, stby_d;

  // a gate may only turn on after the other one was seen off
  always_comb begin
    main_d = want_main && !stby_q;
    stby_d = want_stby && !want_main && !main_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= 1'b0;
      stby_q <= 1'b0;
    end else begin
      main_q <= main_d;
      stby_q <= stby_d;
    end
  end

  assign main_en = main_q;
  assign stby_en = stby_q;

endmodule

// File: rtl/acpi_sleep_ctrl.sv
module acpi_sleep_ctrl
  import sst_pkg::*;
#(
  parameter int unsigned FILT_TICKS = 3,
  parameter int unsigned DELAY_US   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       slp3_req_n,
  input  logic       slp5_req_n,
  input  logic       dual_sleep_en,
  input  logic       mon_3v3_ok,
  input  logic       mon_5v_ok,
  input  logic       mon_12v_ok,
  input  logic       shutdown_req,
  output logic [1:0] pwr_state,
  output logic       main_gate_en,
  output logic       stby_gate_en,
  output logic       clk_rail_en
);
  logic             rst_s1_q, rst_s2_q, rst_int_n;
  logic [REQ_N-1:0] req_raw_n, req_filt_n;
  logic             sup_ok, dly_run, dly_done;
  logic             lat_q, lat_d, lat_ld;
  pwr_state_t       state_q, state_d;
  logic             is_sleep;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  assign req_raw_n = {slp5_req_n, slp3_req_n};

  for (genvar gi = 0; gi < REQ_N; gi++) begin : g_flt
    sst_deglitch #(.FILT_TICKS(FILT_TICKS)) i_flt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .tick   (tick_us),
      .raw_n  (req_raw_n[gi]),
      .filt_n (req_filt_n[gi])
    );
  end

  assign sup_ok  = mon_3v3_ok && mon_5v_ok && mon_12v_ok;
  assign dly_run = (state_q == PS_ACTIVE) && !req_filt_n[0];

  sst_sleep_timer #(.DELAY_US(DELAY_US)) i_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick_us),
    .run   (dly_run),
    .done  (dly_done)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (shutdown_req) begin
      state_d = PS_OFF;
    end else begin
      unique case (state_q)
        PS_OFF:    state_d = PS_S5;
        PS_ACTIVE: begin
          if (!sup_ok)       state_d = PS_S5;
          else if (dly_done) state_d = req_filt_n[1] ? PS_S3 : PS_S5;
        end
        PS_S3, PS_S5: begin
          if (req_filt_n[0] && req_filt_n[1] && sup_ok) state_d = PS_ACTIVE;
        end
        default:   state_d = PS_OFF;
      endcase
    end
  end

  // sleep-support latch: tracks in OFF, captured on entry into sleep
  always_comb begin
    lat_ld = (state_q == PS_OFF) ||
             ((state_q == PS_ACTIVE) && ((state_d == PS_S3) || (state_d == PS_S5)));
    lat_d  = dual_sleep_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= PS_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  lat_q <= 1'b0;
    else if (lat_ld) lat_q <= lat_d;
  end

  assign is_sleep = (state_q == PS_S3) || (state_q == PS_S5);

  sst_gate_drive i_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .want_main (state_q == PS_ACTIVE),
    .want_stby (is_sleep && lat_q),
    .main_en   (main_gate_en),
    .stby_en   (stby_gate_en)
  );

  assign pwr_state   = state_q;
  assign clk_rail_en = (state_q == PS_ACTIVE);

endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       shutdown_req,
  input logic       mon_3v3_ok,
  input logic       mon_5v_ok,
  input logic       mon_12v_ok,
  input logic [1:0] pwr_state,
  input logic       main_gate_en,
  input logic       stby_gate_en,
  input logic       clk_rail_en
);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_gate_en && stby_gate_en));

  a_r12_gap_main_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
    $past(main_gate_en) |-> !stby_gate_en);

  a_r12_gap_stby_to_main: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stby_gate_en) |-> !main_gate_en);

  a_r5_no_s3_to_s5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'd1) |-> (pwr_state != 2'd2));

  a_r5_no_s5_to_s3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'd2) |-> (pwr_state != 2'd1));

  a_r8_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 2'd0) && !(mon_3v3_ok && mon_5v_ok && mon_12v_ok) && !shutdown_req)
    |=> (pwr_state == 2'd2));

  a_r13_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> (pwr_state == 2'd3));

  a_r13_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd3) |=> (!main_gate_en && !stby_gate_en));

  a_r11_clk_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 2'd1) || (pwr_state == 2'd2) || (pwr_state == 2'd3)) |-> !clk_rail_en);

  a_r10_main_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    main_gate_en |-> ($past(pwr_state) == 2'd0));
endmodule

bind acpi_sleep_ctrl sst_checker i_sst_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .shutdown_req (shutdown_req),
  .mon_3v3_ok   (mon_3v3_ok),
  .mon_5v_ok    (mon_5v_ok),
  .mon_12v_ok   (mon_12v_ok),
  .pwr_state    (pwr_state),
  .main_gate_en (main_gate_en),
  .stby_gate_en (stby_gate_en),
  .clk_rail_en  (clk_rail_en)
);

// File: tb/test_acpi_sleep_ctrl.sv
`timescale 1ns/1ps
module test_acpi_sleep_ctrl;
  localparam int FT = 3;
  localparam int DL = 200;
  localparam int TICK_DIV = 4;

  logic clk, rst_n, tick_us, s3n, s5n, dual_en, m33, m5, m12, sd;
  logic [1:0] pwr_state;
  logic main_en, stby_en, clk_en;

  int total = 0, bad = 0, cyc = 0, bbm_err = 0;
  bit done = 0;

  acpi_sleep_ctrl #(.FILT_TICKS(FT), .DELAY_US(DL)) i_acpi_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .slp3_req_n(s3n), .slp5_req_n(s5n), .dual_sleep_en(dual_en),
    .mon_3v3_ok(m33), .mon_5v_ok(m5), .mon_12v_ok(m12), .shutdown_req(sd),
    .pwr_state(pwr_state), .main_gate_en(main_en), .stby_gate_en(stby_en),
    .clk_rail_en(clk_en));

  initial begin clk = 0; forever #10 clk = ~clk; end

  initial begin
    tick_us = 0;
    forever begin
      @(negedge clk);
      tick_us = ((cyc % TICK_DIV) == 0);
    end
  end

  // behavioural reference
  int q_s1[2], q_s2[2], q_f[2], q_c[2];
  int q_tmr, q_st, q_lat, q_main, q_stby;

  always @(posedge clk or negedge rst_n) begin
    int raw[2];
    int ns1[2], ns2[2], nf[2], nc[2];
    int ntmr, nst, nlat, nmain, nstby, ok, run;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin q_s1[i] = 1; q_s2[i] = 1; q_f[i] = 1; q_c[i] = 0; end
      q_tmr = 0; q_st = 3; q_lat = 0; q_main = 0; q_stby = 0;
    end else begin
      raw[0] = s3n; raw[1] = s5n;
      for (int i = 0; i < 2; i++) begin
        ns1[i] = raw[i]; ns2[i] = q_s1[i]; nf[i] = q_f[i]; nc[i] = q_c[i];
        if (q_s2[i] == q_f[i]) nc[i] = 0;
        else if (tick_us) begin
          if (q_c[i] == FT - 1) begin nf[i] = q_s2[i]; nc[i] = 0; end
          else nc[i] = q_c[i] + 1;
        end
      end
      run = (q_st == 0) && (q_f[0] == 0);
      if (!run) ntmr = 0;
      else if (tick_us && q_tmr < DL) ntmr = q_tmr + 1;
      else ntmr = q_tmr;
      ok = m33 && m5 && m12;
      nst = q_st;
      if (sd) nst = 3;
      else if (q_st == 3) nst = 2;
      else if (q_st == 0) begin
        if (!ok) nst = 2;
        else if (run && q_tmr == DL) nst = q_f[1] ? 1 : 2;
      end else if (q_f[0] && q_f[1] && ok) nst = 0;
      nlat = q_lat;
      if (q_st == 3 || (q_st == 0 && (nst == 1 || nst == 2))) nlat = dual_en;
      nmain = (q_st == 0) && !q_stby;
      nstby = (q_st == 1 || q_st == 2) && q_lat && !q_main;
      q_s1 = ns1; q_s2 = ns2; q_f = nf; q_c = nc;
      q_tmr = ntmr; q_st = nst; q_lat = nlat; q_main = nmain; q_stby = nstby;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the reference, plus gate overlap monitor
  int prev_main = 0, prev_stby = 0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && !done) begin
        chk("R5 state vs model", pwr_state, q_st);
        chk("R10 main gate vs model", main_en, q_main);
        chk("R9 standby gate vs model", stby_en, q_stby);
        chk("R11 clock rail vs model", clk_en, (q_st == 0));
        if ((main_en && stby_en) || (prev_main && stby_en) || (prev_stby && main_en)) bbm_err++;
      end
      prev_main = main_en; prev_stby = stby_en;
      if (cyc > 150000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic wc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; s3n = 1; s5n = 1; dual_en = 1; m33 = 1; m5 = 1; m12 = 1; sd = 1;
    wc(5);
    chk("R1 state in reset", pwr_state, 3);
    chk("R1 main gate in reset", main_en, 0);
    chk("R1 standby gate in reset", stby_en, 0);
    chk("R1 clock rail in reset", clk_en, 0);
    rst_n = 1;
    wc(10);
    chk("R13 held off by shutdown", pwr_state, 3);
    sd = 0;
    wc(1);
    chk("R2 OFF exits to S5", pwr_state, 2);
    wc(10);
    chk("R7 wake to active", pwr_state, 0);
    chk("R10 main gate in active", main_en, 1);
    chk("R11 clock rail in active", clk_en, 1);

    // short pulse on the suspend line
    s3n = 0; wc(8); s3n = 1;
    wc(DL * TICK_DIV + 100);
    chk("R3 short pulse rejected", pwr_state, 0);

    // illegal combination in active
    s5n = 0; wc(DL * TICK_DIV + 100);
    chk("R6 hold in active", pwr_state, 0);
    s5n = 1; wc(20);

    // enter S3 with sleep support off
    dual_en = 0; s3n = 0;
    wc(DL * TICK_DIV + 100);
    chk("R4 enter S3", pwr_state, 1);
    chk("R11 clock rail off in S3", clk_en, 0);
    chk("R9 standby gate off (latched 0)", stby_en, 0);
    dual_en = 1; wc(50);
    chk("R9 change during sleep ignored", stby_en, 0);
    s5n = 0; wc(200);
    chk("R5 S3 to S5 refused", pwr_state, 1);
    s3n = 1; wc(200);
    chk("R6 hold in S3", pwr_state, 1);
    s5n = 1; wc(30);
    chk("R7 wake from S3", pwr_state, 0);

    // delay cancelled midway
    s3n = 0; wc(DL * TICK_DIV / 2); s3n = 1; wc(40);
    s3n = 0; wc(DL * TICK_DIV / 2 + 40);
    chk("R4 cancelled delay restarts", pwr_state, 0);
    s3n = 1; wc(40);

    // enter S5 with sleep support on
    s3n = 0; s5n = 0;
    wc(DL * TICK_DIV + 100);
    chk("R4 enter S5", pwr_state, 2);
    chk("R10 standby gate in S5", stby_en, 1);
    chk("R10 main gate off in S5", main_en, 0);
    s5n = 1; wc(200);
    chk("R5 S5 to S3 refused", pwr_state, 2);
    s3n = 1; wc(30);
    chk("R7 wake from S5", pwr_state, 0);

    // supply loss
    m5 = 0; wc(2);
    chk("R8 forced S5", pwr_state, 2);
    wc(100);
    chk("R8 held while supply low", pwr_state, 2);
    m5 = 1; wc(3);
    chk("R8 release on recovery", pwr_state, 0);

    // shutdown from active
    wc(5);
    sd = 1; wc(1);
    chk("R13 shutdown to OFF", pwr_state, 3);
    wc(1);
    chk("R13 gates off", main_en + stby_en, 0);
    sd = 0; wc(10);
    chk("R2 restart after shutdown", pwr_state, 0);

    chk("R12 break-before-make violations", bbm_err, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule